// File: doc/BRIEF.md
# Process-Identifier Change Translation Flush Scanner

This block sits next to a translation buffer and follows the register that holds the current process identifier. A write to that register that carries a value different from the one held starts a sweep: the block steps a read index through every buffer entry, one entry per clock, and inspects each returned tag. Entries that are valid, not shared by all processes, and owned by the outgoing identifier produce a one-cycle invalidate request. The request carries the page-aligned virtual address of the entry, so that any translations cached further downstream can be discarded.

A write that repeats the held identifier starts nothing. While a sweep runs, further writes are dropped entirely. At the end of the sweep a one-cycle completion pulse is raised. The block never modifies buffer contents; it only reads them.

Top module: `tlbf_scanner`

## Requirements
- R1: A write (`id_wr_en` high at a clock edge) starts a sweep only when `id_wr_val` differs from the held identifier; a write of the held value leaves `busy` low and raises no flush request.
- R2: After reset, `busy`, `done` and `flush_vld` are low and the held identifier is 0.
- R3: A sweep presents `tag_rd_idx` = 0, 1, … , ENTRIES−1 in order, one index per clock, beginning in the cycle after the starting write.
- R4: The entry at an index is flushed only when its tag has bit 10 (valid) set, bit 11 (global) clear, and its low PID_W bits equal the identifier held before the starting write (the outgoing one).
- R5: A flush request appears in the cycle after its index is presented, with `flush_addr` equal to the tag with bits 11:0 cleared.
- R6: `busy` is high in every cycle in which a sweep index is presented and low in the cycle after the last one; `done` is high for exactly that one cycle.
- R7: A write while `busy` is high is ignored: the sweep runs on unchanged, and the held identifier is not updated, so a later write of that same value still starts a sweep.
- R8: `flush_vld` is a single-cycle strobe per matching entry, and it is never high when no matching entry was presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_wr_en | input | 1 | Process-identifier register write strobe |
| id_wr_val | input | PID_W | Value written to the identifier register |
| tag_rd_idx | output | IDX_W | Entry index presented to tag storage |
| tag_rd_data | input | TAG_W | Tag returned combinationally for `tag_rd_idx` |
| flush_vld | output | 1 | One-cycle page invalidate request |
| flush_addr | output | TAG_W | Page-aligned virtual address to invalidate |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds the block with 8 entries and a 4-bit identifier, which makes it practical to walk the identifier through every one of its 16 values and hence to sweep with every possible outgoing identifier. Tag storage is a bench array filled arithmetically so that each combination of valid, global and matching/non-matching identifier occurs across the sweeps, and every index of every sweep is compared cycle by cycle against the expected flush decision and address. Repeated writes and writes landing mid-sweep are exercised at several indices.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
    localparam int PAGE_BITS  = 12;
    localparam int VALID_BIT  = 10;
    localparam int GLOBAL_BIT = 11;
endpackage

// File: rtl/tlbf_entry_match.sv
module tlbf_entry_match
    import tlbf_pkg::*;
#(
    parameter int TAG_W = 32,
    parameter int PID_W = 8
) (
    input  logic [TAG_W-1:0] tag,
    input  logic [PID_W-1:0] victim_id,
    output logic             hit
);
    logic owner_eq;
    assign owner_eq = (tag[PID_W-1:0] == victim_id);
    assign hit      = tag[VALID_BIT] & ~tag[GLOBAL_BIT] & owner_eq;
endmodule

// File: rtl/tlbf_page_base.sv
module tlbf_page_base
    import tlbf_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic [TAG_W-1:0] tag,
    output logic [TAG_W-1:0] page
);
    assign page = {tag[TAG_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
endmodule

// File: rtl/tlbf_scanner.sv
module tlbf_scanner
    import tlbf_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PID_W   = 8,
    parameter int TAG_W   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_wr_en,
    input  logic [PID_W-1:0] id_wr_val,
    output logic [IDX_W-1:0] tag_rd_idx,
    input  logic [TAG_W-1:0] tag_rd_data,
    output logic             flush_vld,
    output logic [TAG_W-1:0] flush_addr,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             flush_vld;
        logic [TAG_W-1:0] flush_addr;
        logic [IDX_W-1:0] idx;
        logic [PID_W-1:0] victim_id;
        logic [PID_W-1:0] cur_id;
    } state_t;

    state_t st_q, st_d;
    logic             entry_hit;
    logic [TAG_W-1:0] entry_page;
    logic             start_req;

    tlbf_entry_match #(.TAG_W(TAG_W), .PID_W(PID_W)) u_match (
        .tag       (tag_rd_data),
        .victim_id (st_q.victim_id),
        .hit       (entry_hit)
    );

    tlbf_page_base #(.TAG_W(TAG_W)) u_page (
        .tag  (tag_rd_data),
        .page (entry_page)
    );

    assign start_req = id_wr_en && !st_q.busy && (id_wr_val != st_q.cur_id);

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.flush_vld = 1'b0;
        if (st_q.busy) begin
            st_d.flush_vld = entry_hit;
            if (entry_hit) begin
                st_d.flush_addr = entry_page;
            end
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start_req) begin
            st_d.busy      = 1'b1;
            st_d.idx       = '0;
            st_d.victim_id = st_q.cur_id;
            st_d.cur_id    = id_wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_rd_idx = st_q.idx;
    assign flush_vld  = st_q.flush_vld;
    assign flush_addr = st_q.flush_addr;
    assign busy       = st_q.busy;
    assign done       = st_q.done;

    // R1
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(id_wr_en));

    // R1
    same_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wr_en && !busy && id_wr_val == st_q.cur_id) |=> !busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tag_rd_idx == LAST_IDX) |=> (done && !busy));

    // R7
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tag_rd_idx != LAST_IDX) |=> busy);

    // R8
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |-> $past(busy));

    // R5
    flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld |-> (flush_addr[PAGE_BITS-1:0] == '0));
endmodule

// File: tb/tlbf_scanner_test.sv
module tlbf_scanner_test;
    localparam int  ENTRIES = 8;
    localparam int  PID_W   = 4;
    localparam int  TAG_W   = 32;
    localparam int  IDX_W   = 3;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             id_wr_en = 1'b0;
    logic [PID_W-1:0] id_wr_val = '0;
    logic [IDX_W-1:0] tag_rd_idx;
    logic [TAG_W-1:0] tag_rd_data;
    logic             flush_vld;
    logic [TAG_W-1:0] flush_addr;
    logic             busy;
    logic             done;

    logic [TAG_W-1:0] mem [ENTRIES];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tag_rd_data = mem[tag_rd_idx];

    tlbf_scanner #(.ENTRIES(ENTRIES), .PID_W(PID_W), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_wr_val(id_wr_val),
        .tag_rd_idx(tag_rd_idx), .tag_rd_data(tag_rd_data),
        .flush_vld(flush_vld), .flush_addr(flush_addr),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [TAG_W-1:0] act,
                         input logic [TAG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] make_tag(int i, int seed);
        logic [19:0] vpn;
        logic        g, v;
        logic [9:0]  owner;
        vpn   = 20'((i * 40503 + seed * 977 + 1) & 20'hFFFFF);
        g     = ((i + seed) % 5) == 0;
        v     = ((i * 3 + seed) % 4) != 1;
        owner = 10'(((i * 7 + seed * 3) % 16) | ((seed & 3) << 6));
        return {vpn, g, v, owner};
    endfunction

    task automatic fill(int seed);
        for (int i = 0; i < ENTRIES; i++) mem[i] = make_tag(i, seed);
    endtask

    // Write an identifier and follow the full sweep; ign_at >= 0 injects a
    // write of ign_val while the sweep runs at that index.
    task automatic sweep(input logic [PID_W-1:0] old_id, input logic [PID_W-1:0] new_id,
                         input int ign_at, input logic [PID_W-1:0] ign_val);
        logic [TAG_W-1:0] t;
        logic hit;
        id_wr_en = 1'b1; id_wr_val = new_id;
        @(posedge clk); @(negedge clk);
        id_wr_en = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            // R3 R6: index presented while busy
            check("R6 busy during sweep", {31'd0, busy}, 1);
            check("R3 index order", TAG_W'(tag_rd_idx), TAG_W'(i));
            t = mem[i];
            hit = t[10] && !t[11] && (t[PID_W-1:0] == old_id);
            if (i == ign_at) begin id_wr_en = 1'b1; id_wr_val = ign_val; end
            @(posedge clk); @(negedge clk);
            id_wr_en = 1'b0;
            // R4 R8: flush decision uses outgoing identifier
            check("R4 flush decision", {31'd0, flush_vld}, {31'd0, hit});
            // R5: page aligned address
            if (hit) check("R5 flush address", flush_addr, {t[31:12], 12'h000});
            check("R6 done pulse", {31'd0, done}, (i == ENTRIES-1) ? 1 : 0);
        end
        check("R6 busy after sweep", {31'd0, busy}, 0);
        @(posedge clk); @(negedge clk);
        check("R6 done one cycle", {31'd0, done}, 0);
        check("R8 strobe one cycle", {31'd0, flush_vld}, 0);
    endtask

    // R1: write of the held value
    task automatic same_write(input logic [PID_W-1:0] val);
        id_wr_en = 1'b1; id_wr_val = val;
        @(posedge clk); @(negedge clk);
        id_wr_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R1 no sweep on equal write", {31'd0, busy}, 0);
            check("R1 no flush on equal write", {31'd0, flush_vld}, 0);
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        logic [PID_W-1:0] cur;
        fill(0);
        repeat (2) @(negedge clk);
        // R2: reset state
        check("R2 busy at reset", {31'd0, busy}, 0);
        check("R2 done at reset", {31'd0, done}, 0);
        check("R2 flush at reset", {31'd0, flush_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: held identifier is 0, so writing 0 starts nothing
        same_write(0);
        cur = 0;
        for (int p = 1; p < 16; p++) begin
            fill(p);
            sweep(cur, PID_W'(p), -1, '0);
            cur = PID_W'(p);
            same_write(cur);
        end
        fill(3);
        sweep(cur, 0, -1, '0);
        cur = 0;
        // R7: writes during sweeps are dropped at several positions
        for (int a = 0; a < ENTRIES; a += 3) begin
            fill(a + 20);
            sweep(cur, PID_W'(a + 1), a, PID_W'(a + 9));
            cur = PID_W'(a + 1);
            // ignored value never became current: it starts a sweep now
            sweep(cur, PID_W'(a + 9), -1, '0);
            cur = PID_W'(a + 9);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule